// File: doc/BRIEF.md
# LCD Vertical Frame Timing Generator

This block sequences the vertical part of an LCD frame. It counts line periods, marked by a one-cycle line enable from the horizontal timing logic, and moves through four phases in a fixed order. A frame begins with the active lines, goes on to a front porch and a sync phase, and ends with a back porch. Then the next frame begins. The block reports which phase holds the current line period: it raises a vertical sync strobe, an active-line flag with the line index, and a one-cycle pulse when a frame begins.

All of the timing comes from one packed configuration word and a panel-type input. The configuration word holds the active line count, the sync width, the front porch and the back porch. The panel-type input selects an active panel or a passive panel. The block samples both only when a frame begins, so software can rewrite them at any time and the new values take effect from the next frame. On a passive panel the sync phase still takes up its line periods, but the sync strobe stays low.

Top module: `vtg_vertical_timing`

## Requirements
- R1: The configuration word holds the active line count minus one in bits 9:0, so each frame has that field + 1 active lines (1 to 1024). During the active phase `line_idx_o` counts 0, 1, … up to the field value.
- R2: Bits 15:10 hold the sync width minus one. The sync phase lasts that field + 1 line periods.
- R3: Bits 23:16 are a raw front-porch count (0 to 255). That many inactive line periods follow the last active line. A count of zero skips the phase.
- R4: Bits 31:24 are a raw back-porch count (0 to 255). That many inactive line periods start on the line period right after the sync phase. A count of zero skips the phase.
- R5: The phases always run in this order: active lines, front porch, sync, back porch, then the active lines of the next frame.
- R6: With `panel_active_i` = 1 latched, `vsync_o` is high for every line period of the sync phase and low at all other times. With 0 latched (passive panel), `vsync_o` never goes high, but the sync phase still lasts as long as R2 gives.
- R7: The phase and the line counters advance only on clock cycles where `line_en_i` is high. On all other cycles every output holds its value, apart from the end of a frame-start pulse.
- R8: The configuration word and `panel_active_i` are sampled only when a frame begins. A change made during a frame has no effect until the next frame.
- R9: Reset sets all four latched fields to zero and selects the passive panel. The block leaves reset on active line 0 with `frame_start_o` high, so the first frame has 1 active line and 1 sync line.
- R10: `frame_start_o` is high for exactly one clock cycle, on entry to active line 0 of each frame, and at no other time.
- R11: Outside the active phase `line_active_o` is 0 and `line_idx_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_en_i | input | 1 | One-cycle strobe, one per line period |
| panel_active_i | input | 1 | 1 = active panel (sync strobe driven), 0 = passive panel |
| timing_cfg_i | input | 32 | Packed line count, sync width, front porch and back porch |
| vsync_o | output | 1 | Vertical sync strobe |
| line_active_o | output | 1 | High during the active lines |
| line_idx_o | output | 10 | Index of the current active line |
| frame_start_o | output | 1 | One-cycle pulse on entry to the first active line |

## Verification
The bench builds the block with its default field widths, so the packed word keeps its full 32-bit layout. It sweeps line counts 1 to 4, sync widths 1 to 3 and both porches 0 to 2, each with both panel types. This reaches every skipped-porch combination and the passive-panel sync case. One frame with every field at its maximum covers the largest counts at the top of each range. Inside each frame the configuration word is scrambled and later restored, and the gaps between line enables vary, to show both the frame-boundary sampling and that the block holds still between enables.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } vtg_phase_e;
endpackage

// File: rtl/vtg_cfg_reg.sv
module vtg_cfg_reg #(
  parameter int LINE_W  = 10,
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  localparam int CFG_W  = LINE_W + SYNC_W + 2 * PORCH_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CFG_W-1:0]   word_i,
  input  logic               mode_i,
  output logic [LINE_W-1:0]  lpp_o,
  output logic [SYNC_W-1:0]  vsw_o,
  output logic [PORCH_W-1:0] fp_o,
  output logic [PORCH_W-1:0] bp_o,
  output logic               mode_o
);
  localparam int SYNC_LSB = LINE_W;
  localparam int FP_LSB   = SYNC_LSB + SYNC_W;
  localparam int BP_LSB   = FP_LSB + PORCH_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lpp_o  <= '0;
      vsw_o  <= '0;
      fp_o   <= '0;
      bp_o   <= '0;
      mode_o <= 1'b0;
    end else if (load_i) begin
      lpp_o  <= word_i[LINE_W-1:0];
      vsw_o  <= word_i[SYNC_LSB +: SYNC_W];
      fp_o   <= word_i[FP_LSB +: PORCH_W];
      bp_o   <= word_i[BP_LSB +: PORCH_W];
      mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/vtg_seq.sv
module vtg_seq
  import vtg_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  localparam int CNT_W  = (LINE_W >= PORCH_W)
                          ? ((LINE_W >= SYNC_W) ? LINE_W : SYNC_W)
                          : ((PORCH_W >= SYNC_W) ? PORCH_W : SYNC_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_en_i,
  input  logic [LINE_W-1:0]  lpp_i,
  input  logic [SYNC_W-1:0]  vsw_i,
  input  logic [PORCH_W-1:0] fp_i,
  input  logic [PORCH_W-1:0] bp_i,
  output vtg_phase_e         phase_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o
);
  vtg_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wrap_o  = 1'b0;
    if (line_en_i) begin
      unique case (phase_q)
        PH_ACT: begin
          if (cnt_q == CNT_W'(lpp_i)) begin
            cnt_d   = '0;
            phase_d = (fp_i != '0) ? PH_FP : PH_SYNC;
          end else cnt_d = cnt_inc;
        end
        PH_FP: begin
          if (cnt_inc == CNT_W'(fp_i)) begin
            cnt_d   = '0;
            phase_d = PH_SYNC;
          end else cnt_d = cnt_inc;
        end
        PH_SYNC: begin
          if (cnt_q == CNT_W'(vsw_i)) begin
            cnt_d = '0;
            if (bp_i != '0) phase_d = PH_BP;
            else begin
              phase_d = PH_ACT;
              wrap_o  = 1'b1;
            end
          end else cnt_d = cnt_inc;
        end
        PH_BP: begin
          if (cnt_inc == CNT_W'(bp_i)) begin
            cnt_d   = '0;
            phase_d = PH_ACT;
            wrap_o  = 1'b1;
          end else cnt_d = cnt_inc;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACT;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  a_r7_hold_without_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_en_i |=> $stable(phase_q) && $stable(cnt_q));
  a_r1_active_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_ACT |-> cnt_q <= CNT_W'(lpp_i));
  a_r2_sync_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_SYNC |-> cnt_q <= CNT_W'(vsw_i));
  a_r5_fp_leads_to_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_FP |=> phase_q inside {PH_FP, PH_SYNC});
  a_r5_bp_leads_to_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_BP |=> phase_q inside {PH_BP, PH_ACT});
endmodule

// File: rtl/vtg_vertical_timing.sv
module vtg_vertical_timing
  import vtg_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  localparam int CFG_W  = LINE_W + SYNC_W + 2 * PORCH_W,
  localparam int CNT_W  = (LINE_W >= PORCH_W)
                          ? ((LINE_W >= SYNC_W) ? LINE_W : SYNC_W)
                          : ((PORCH_W >= SYNC_W) ? PORCH_W : SYNC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_en_i,
  input  logic              panel_active_i,
  input  logic [CFG_W-1:0]  timing_cfg_i,
  output logic              vsync_o,
  output logic              line_active_o,
  output logic [LINE_W-1:0] line_idx_o,
  output logic              frame_start_o
);
  logic [LINE_W-1:0]  lpp;
  logic [SYNC_W-1:0]  vsw;
  logic [PORCH_W-1:0] fp, bp;
  logic               mode_q, wrap;
  vtg_phase_e         phase;
  logic [CNT_W-1:0]   cnt;

  vtg_cfg_reg #(.LINE_W(LINE_W), .SYNC_W(SYNC_W), .PORCH_W(PORCH_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap),
    .word_i (timing_cfg_i),
    .mode_i (panel_active_i),
    .lpp_o  (lpp),
    .vsw_o  (vsw),
    .fp_o   (fp),
    .bp_o   (bp),
    .mode_o (mode_q)
  );

  vtg_seq #(.LINE_W(LINE_W), .SYNC_W(SYNC_W), .PORCH_W(PORCH_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_en_i (line_en_i),
    .lpp_i     (lpp),
    .vsw_i     (vsw),
    .fp_i      (fp),
    .bp_i      (bp),
    .phase_o   (phase),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  // reset lands on line 0 of a frame, so the pulse starts high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_start_o <= 1'b1;
    else         frame_start_o <= wrap;
  end

  assign line_active_o = (phase == PH_ACT);
  assign line_idx_o    = line_active_o ? cnt[LINE_W-1:0] : '0;
  assign vsync_o       = mode_q && (phase == PH_SYNC);

  a_r6_passive_no_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> !vsync_o);
  a_r10_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  a_r10_on_first_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_active_o && line_idx_o == '0);
endmodule

// File: tb/vtg_vertical_timing_test.sv
module vtg_vertical_timing_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_en_i = 1'b0;
  logic        panel_active_i = 1'b0;
  logic [31:0] timing_cfg_i = '0;
  logic        vsync_o, line_active_o, frame_start_o;
  logic [9:0]  line_idx_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  vtg_vertical_timing uut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .line_en_i      (line_en_i),
    .panel_active_i (panel_active_i),
    .timing_cfg_i   (timing_cfg_i),
    .vsync_o        (vsync_o),
    .line_active_o  (line_active_o),
    .line_idx_o     (line_idx_o),
    .frame_start_o  (frame_start_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i) line_en_i = 1'b1;
    @(negedge clk_i) line_en_i = 1'b0;
  endtask

  // runs one frame with latched config cur; presents nxt for the next frame
  task automatic run_frame(input logic [31:0] cur, input bit cmode,
                           input logic [31:0] nxt, input bit nmode, input int seed);
    int l_n = int'(cur[9:0]) + 1;
    int s_n = int'(cur[15:10]) + 1;
    int f_n = int'(cur[23:16]);
    int b_n = int'(cur[31:24]);
    int t_n = l_n + f_n + s_n + b_n;
    for (int k = 0; k < t_n; k++) begin
      int ph;
      string tag;
      bit ea, ev;
      int ei;
      ph  = (k < l_n) ? 0 : (k < l_n + f_n) ? 1 : (k < l_n + f_n + s_n) ? 2 : 3;
      tag = (ph == 0) ? "R1 R5 active" : (ph == 1) ? "R3 R5 front porch" :
            (ph == 2) ? "R2 R5 sync" : "R4 R5 back porch";
      ea  = (ph == 0);
      ei  = ea ? k : 0;
      ev  = (ph == 2) && cmode;
      chk(line_active_o == ea, tag, int'(line_active_o), int'(ea));
      chk(int'(line_idx_o) == ei, "R1 R11 line index", int'(line_idx_o), ei);
      chk(vsync_o == ev, "R6 vsync", int'(vsync_o), int'(ev));
      chk(frame_start_o == (k == 0), "R10 frame start", int'(frame_start_o), int'(k == 0));
      if (k == 0) begin
        timing_cfg_i   = ~nxt;       // R8: mid-frame scramble must not apply
        panel_active_i = ~nmode;
      end
      if (k == t_n - 1) begin
        timing_cfg_i   = nxt;
        panel_active_i = nmode;
      end
      for (int g = 0; g < (k + seed) % 3; g++) begin
        @(negedge clk_i);
        chk(line_active_o == ea && int'(line_idx_o) == ei && vsync_o == ev,
            "R7 hold without enable", int'(line_idx_o), ei);
        chk(!frame_start_o, "R10 pulse ends", int'(frame_start_o), 0);
      end
      step();
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] cur, nw;
    bit cm, nm;
    int seed;
    repeat (3) @(negedge clk_i);
    chk(frame_start_o && line_active_o && line_idx_o == '0 && !vsync_o,
        "R9 reset state", int'(frame_start_o), 1);
    rst_ni = 1'b1;
    cur  = '0;
    cm   = 1'b0;
    seed = 0;
    for (int lp = 0; lp < 4; lp++)
      for (int vs = 0; vs < 3; vs++)
        for (int fp = 0; fp < 3; fp++)
          for (int bp = 0; bp < 3; bp++)
            for (int md = 0; md < 2; md++) begin
              nw = {8'(bp), 8'(fp), 6'(vs), 10'(lp)};
              nm = bit'(md);
              run_frame(cur, cm, nw, nm, seed);   // first call: R9 zero config
              cur = nw;
              cm  = nm;
              seed++;
            end
    run_frame(cur, cm, 32'hFFFF_FFFF, 1'b1, seed);
    run_frame(32'hFFFF_FFFF, 1'b1, 32'h0, 1'b0, seed + 1);
    run_frame(32'h0, 1'b0, 32'h0, 1'b0, seed + 2);
    chk(frame_start_o && line_active_o, "R10 final frame entry", int'(frame_start_o), 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule